// File: doc/BRIEF.md
# IO Page-Table Entry Cache Invalidation Engine

This block keeps a small, fully associative cache of IO page-table entries, tagged by the physical address of each entry. It also provides one 64-bit command register that drops a run of consecutive entries from that cache. Software writes a single word that holds three things: how many entries to drop, the entry-aligned address of the first one, and a busy flag set to one. The engine compares every cached tag against the whole address range at the same time. It clears each entry that falls inside the range and then lowers the busy flag by itself. Software polls the register until the flag reads zero.

A table-walk agent that sits outside this block loads entries through a fill port with a ready/valid handshake. Translation logic reads the cache through a combinational lookup port. The fill port is held off for the whole of a sweep. Because of this, an entry that is being invalidated cannot be written back into the cache halfway through the sweep. A single command covers from 1 to 2048 entries. A longer range takes several commands in a row.

Top module: `pte_cache_inval`

## Requirements
- R1: After reset, the command register reads zero at byte offset 0x908, every lookup misses, and fill_ready is high.
- R2: A write to offset 0x908 while the register is idle stores the whole word. Bits 63:53 are the count, bits 41:3 are the start tag (entry address divided by 8), and bit 0 is busy. If bit 0 of the written word is one, a sweep starts, and the next read returns the written word with bit 0 set.
- R3: Busy stays one for exactly two clock cycles after the write edge, whatever the count, and then clears by itself. All other bits keep the value that was written.
- R4: A sweep invalidates every valid entry whose tag t satisfies start <= t < start + count. Every other entry keeps its tag and data.
- R5: A count field of zero means 2048 entries.
- R6: While busy is one, writes to the command register are ignored.
- R7: fill_ready is low while busy is one. A fill held on the port during a sweep is not taken. It is accepted on the first edge after busy clears, and the new entry remains valid after the sweep.
- R8: A fill whose tag is already cached overwrites that entry's data. No two valid entries ever hold the same tag.
- R9: A fill with a new tag goes to the lowest-numbered free entry. When the cache is full, it replaces a round-robin victim instead; the victim pointer starts at entry 0 after reset and advances only on such replacements.
- R10: A write to offset 0x908 with bit 0 clear stores the word but starts no sweep, so no entry is dropped.
- R11: Writes to any other offset change nothing, and reads there return zero.
- R12: The lookup port reports hit and the cached data of a valid entry with the requested tag in the same cycle.
- R13: The range end is computed with one extra bit, so a range that runs past the top tag does not wrap around to low tags.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 64 | Register write data |
| reg_rdata | output | 64 | Register read data (combinational on reg_addr) |
| fill_valid | input | 1 | Fill request valid |
| fill_tag | input | 39 | Entry address bits 41:3 of the fill |
| fill_data | input | 64 | Page-table entry value to cache |
| fill_ready | output | 1 | Fill accepted on the edge when valid and ready |
| lk_tag | input | 39 | Lookup tag |
| lk_hit | output | 1 | Lookup hit |
| lk_data | output | 64 | Cached entry value on hit, zero on miss |

## Verification
The properties assume that every fill arrives only through the handshaked port and that inputs carry known values once reset is released. Under those assumptions, tag uniqueness and the ban on a new valid entry appearing during a sweep can be stated purely in terms of internal state. The burst-timing property assumes busy can only rise from an accepted write. The stimulus applies reset first and changes every input on the falling clock edge. It keeps a fill request asserted until fill_ready has been seen high, so fills blocked during a sweep are accepted only after it ends. Range commands are placed so that their boundaries land exactly on cached tags at start-1, start, start+count-1 and start+count, and at the top of the tag space.

// File: rtl/pte_inval_pkg.sv
package pte_inval_pkg;

   localparam int CMD_W    = 64;
   localparam int BUSY_BIT = 0;

   // Remaining sweep phases; PH_FIRST is used only by the registered-match variant.
   typedef enum logic [1:0] {
      PH_IDLE  = 2'd0,
      PH_LAST  = 2'd1,
      PH_FIRST = 2'd2
   } sweep_phase_e;

   function automatic int sweep_cycles(input int match_stage);
      return (match_stage != 0) ? 2 : 1;
   endfunction

endpackage

// File: rtl/pte_inval_cmd.sv
module pte_inval_cmd
   import pte_inval_pkg::*;
#(
   parameter int REG_AW      = 12,
   parameter int CMD_OFFSET  = 'h908,
   parameter int CNT_W       = 11,
   parameter int TAG_W       = 39,
   parameter int TAG_LSB     = 3,
   parameter int MATCH_STAGE = 1
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  reg_we,
   input  logic [REG_AW-1:0]     reg_addr,
   input  logic [CMD_W-1:0]      reg_wdata,
   output logic [CMD_W-1:0]      reg_rdata,
   output logic                  busy_o,
   output logic                  capture_o,
   output logic                  inval_en_o,
   output logic [TAG_W-1:0]      start_tag_o,
   output logic [CNT_W:0]        count_eff_o
);

   localparam int SWEEP   = sweep_cycles(MATCH_STAGE);
   localparam int CNT_LSB = CMD_W - CNT_W;

   logic [CMD_W-1:0] cmd_q;
   sweep_phase_e     phase_q;
   logic             sel;
   logic             wr_ok;
   logic [CNT_W-1:0] cnt_raw;

   assign sel   = (reg_addr == REG_AW'(CMD_OFFSET));
   assign wr_ok = reg_we && sel && !cmd_q[BUSY_BIT];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_q   <= '0;
         phase_q <= PH_IDLE;
      end else if (wr_ok) begin
         cmd_q <= reg_wdata;
         if (reg_wdata[BUSY_BIT])
            phase_q <= (SWEEP == 2) ? PH_FIRST : PH_LAST;
      end else begin
         case (phase_q)
            PH_FIRST: phase_q <= PH_LAST;
            PH_LAST: begin
               phase_q          <= PH_IDLE;
               cmd_q[BUSY_BIT]  <= 1'b0;
            end
            default: ;
         endcase
      end
   end

   assign cnt_raw     = cmd_q[CNT_LSB +: CNT_W];
   assign count_eff_o = (cnt_raw == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cnt_raw};
   assign start_tag_o = cmd_q[TAG_LSB +: TAG_W];
   assign busy_o      = cmd_q[BUSY_BIT];
   assign capture_o   = (phase_q == PH_FIRST);
   assign inval_en_o  = (phase_q == PH_LAST);
   assign reg_rdata   = sel ? cmd_q : '0;

   // R2: an accepted write with the busy bit set leaves busy raised
   a_r2_start_sets_busy: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && reg_wdata[BUSY_BIT]) |=> cmd_q[BUSY_BIT]);

   // R3: the busy window lasts exactly SWEEP cycles
   a_r3_busy_window: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cmd_q[BUSY_BIT]) |-> ##SWEEP !cmd_q[BUSY_BIT]);

   // R6: command fields hold while a sweep is running
   a_r6_fields_held: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_q[BUSY_BIT] |=> $stable(cmd_q[CMD_W-1:1]));

endmodule

// File: rtl/pte_inval_match.sv
module pte_inval_match #(
   parameter int ENTRIES     = 16,
   parameter int TAG_W       = 39,
   parameter int CNT_W       = 11,
   parameter int MATCH_STAGE = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               capture_i,
   input  logic [ENTRIES-1:0] valid_i,
   input  logic [TAG_W-1:0]   tags_i [ENTRIES],
   input  logic [TAG_W-1:0]   start_tag_i,
   input  logic [CNT_W:0]     count_eff_i,
   output logic [ENTRIES-1:0] mask_o
);

   logic [TAG_W:0]     end_c;
   logic [ENTRIES-1:0] hit_c;

   // one extra bit so a range past the top tag never wraps (R13)
   assign end_c = {1'b0, start_tag_i} + (TAG_W+1)'(count_eff_i);

   for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      assign hit_c[g] = valid_i[g]
                     && (tags_i[g] >= start_tag_i)
                     && ({1'b0, tags_i[g]} < end_c);
   end

   if (MATCH_STAGE != 0) begin : g_reg
      logic [ENTRIES-1:0] mask_q;
      always_ff @(posedge clk) begin
         if (!rst_n)
            mask_q <= '0;
         else if (capture_i)
            mask_q <= hit_c;
      end
      assign mask_o = mask_q;
   end else begin : g_comb
      logic unused_c;
      assign unused_c = &{1'b0, clk, rst_n, capture_i};
      assign mask_o   = hit_c;
   end

endmodule

// File: rtl/pte_tag_cache.sv
module pte_tag_cache #(
   parameter int ENTRIES = 16,
   parameter int TAG_W   = 39,
   parameter int DATA_W  = 64
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               busy_i,
   input  logic               fill_we_i,
   input  logic [TAG_W-1:0]   fill_tag_i,
   input  logic [DATA_W-1:0]  fill_data_i,
   input  logic               inval_en_i,
   input  logic [ENTRIES-1:0] inval_mask_i,
   input  logic [TAG_W-1:0]   lk_tag_i,
   output logic               lk_hit_o,
   output logic [DATA_W-1:0]  lk_data_o,
   output logic [ENTRIES-1:0] valid_o,
   output logic [TAG_W-1:0]   tags_o [ENTRIES]
);

   localparam int IDX_W = (ENTRIES > 1) ? $clog2(ENTRIES) : 1;

   logic [ENTRIES-1:0] valid_q;
   logic [TAG_W-1:0]   tag_q  [ENTRIES];
   logic [DATA_W-1:0]  data_q [ENTRIES];
   logic [IDX_W-1:0]   victim_q;

   logic               fhit_c, free_c;
   logic [IDX_W-1:0]   fhit_idx_c, free_idx_c, wr_idx_c;
   logic               dup_c;

   always_comb begin
      fhit_c     = 1'b0;
      fhit_idx_c = '0;
      free_c     = 1'b0;
      free_idx_c = '0;
      lk_hit_o   = 1'b0;
      lk_data_o  = '0;
      for (int i = ENTRIES - 1; i >= 0; i--) begin
         if (valid_q[i] && tag_q[i] == fill_tag_i) begin
            fhit_c     = 1'b1;
            fhit_idx_c = IDX_W'(i);
         end
         if (!valid_q[i]) begin
            free_c     = 1'b1;
            free_idx_c = IDX_W'(i);
         end
         if (valid_q[i] && tag_q[i] == lk_tag_i) begin
            lk_hit_o  = 1'b1;
            lk_data_o = data_q[i];
         end
      end
      wr_idx_c = fhit_c ? fhit_idx_c : (free_c ? free_idx_c : victim_q);
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         valid_q  <= '0;
         victim_q <= '0;
         for (int i = 0; i < ENTRIES; i++) begin
            tag_q[i]  <= '0;
            data_q[i] <= '0;
         end
      end else begin
         if (inval_en_i)
            valid_q <= valid_q & ~inval_mask_i;
         if (fill_we_i) begin
            valid_q[wr_idx_c] <= 1'b1;
            tag_q[wr_idx_c]   <= fill_tag_i;
            data_q[wr_idx_c]  <= fill_data_i;
            if (!fhit_c && !free_c)
               victim_q <= (victim_q == IDX_W'(ENTRIES - 1)) ? '0 : victim_q + 1'b1;
         end
      end
   end

   assign valid_o = valid_q;
   assign tags_o  = tag_q;

   always_comb begin
      dup_c = 1'b0;
      for (int a = 0; a < ENTRIES; a++)
         for (int b = a + 1; b < ENTRIES; b++)
            if (valid_q[a] && valid_q[b] && tag_q[a] == tag_q[b])
               dup_c = 1'b1;
   end

   // R4: entries selected by the range matcher are gone after the clear
   a_r4_range_cleared: assert property (@(posedge clk) disable iff (!rst_n)
      inval_en_i |=> ((valid_q & $past(inval_mask_i)) == '0));

   // R7: no entry becomes valid while a sweep is running
   a_r7_no_fill_in_sweep: assert property (@(posedge clk) disable iff (!rst_n)
      busy_i |=> ((valid_q & ~$past(valid_q)) == '0));

   // R8: a tag is cached at most once
   a_r8_unique_tags: assert property (@(posedge clk) disable iff (!rst_n) !dup_c);

endmodule

// File: rtl/pte_cache_inval.sv
module pte_cache_inval
   import pte_inval_pkg::*;
#(
   parameter int ENTRIES     = 16,
   parameter int CNT_W       = 11,
   parameter int PA_MSB      = 41,
   parameter int PA_LSB      = 3,
   parameter int DATA_W      = 64,
   parameter int REG_AW      = 12,
   parameter int CMD_OFFSET  = 'h908,
   parameter int MATCH_STAGE = 1,
   localparam int TAG_W      = PA_MSB - PA_LSB + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_we,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [63:0]       reg_wdata,
   output logic [63:0]       reg_rdata,
   input  logic              fill_valid,
   input  logic [TAG_W-1:0]  fill_tag,
   input  logic [DATA_W-1:0] fill_data,
   output logic              fill_ready,
   input  logic [TAG_W-1:0]  lk_tag,
   output logic              lk_hit,
   output logic [DATA_W-1:0] lk_data
);

   if (ENTRIES < 2 || ENTRIES > 64) begin : g_bad_entries
      $error("ENTRIES must lie in 2..64");
   end
   if (PA_LSB < 1 || PA_MSB >= CMD_W - CNT_W) begin : g_bad_field
      $error("address field overlaps busy or count");
   end
   if (CNT_W < 1 || TAG_W <= CNT_W) begin : g_bad_count
      $error("count width must be positive and below the tag width");
   end
   if (MATCH_STAGE != 0 && MATCH_STAGE != 1) begin : g_bad_stage
      $error("MATCH_STAGE must be 0 or 1");
   end

   logic               busy, capture, inval_en, fill_we;
   logic [TAG_W-1:0]   start_tag;
   logic [CNT_W:0]     count_eff;
   logic [ENTRIES-1:0] valid, mask;
   logic [TAG_W-1:0]   tags [ENTRIES];

   assign fill_ready = !busy;
   assign fill_we    = fill_valid && fill_ready;

   pte_inval_cmd #(
      .REG_AW(REG_AW), .CMD_OFFSET(CMD_OFFSET), .CNT_W(CNT_W),
      .TAG_W(TAG_W), .TAG_LSB(PA_LSB), .MATCH_STAGE(MATCH_STAGE)
   ) u_cmd (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy_o(busy),
      .capture_o(capture), .inval_en_o(inval_en),
      .start_tag_o(start_tag), .count_eff_o(count_eff)
   );

   pte_inval_match #(
      .ENTRIES(ENTRIES), .TAG_W(TAG_W), .CNT_W(CNT_W), .MATCH_STAGE(MATCH_STAGE)
   ) u_match (
      .clk(clk), .rst_n(rst_n), .capture_i(capture), .valid_i(valid),
      .tags_i(tags), .start_tag_i(start_tag), .count_eff_i(count_eff),
      .mask_o(mask)
   );

   pte_tag_cache #(
      .ENTRIES(ENTRIES), .TAG_W(TAG_W), .DATA_W(DATA_W)
   ) u_cache (
      .clk(clk), .rst_n(rst_n), .busy_i(busy), .fill_we_i(fill_we),
      .fill_tag_i(fill_tag), .fill_data_i(fill_data),
      .inval_en_i(inval_en), .inval_mask_i(mask),
      .lk_tag_i(lk_tag), .lk_hit_o(lk_hit), .lk_data_o(lk_data),
      .valid_o(valid), .tags_o(tags)
   );

endmodule

// File: tb/sim_pte_cache_inval.sv
`timescale 1ns/100ps
module sim_pte_cache_inval;

   localparam int TW = 39;
   localparam logic [11:0] OFF = 12'h908;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_we = 1'b0;
   logic [11:0]   reg_addr = OFF;
   logic [63:0]   reg_wdata = '0;
   logic [63:0]   reg_rdata;
   logic          fill_valid = 1'b0;
   logic [TW-1:0] fill_tag = '0;
   logic [63:0]   fill_data = '0;
   logic          fill_ready;
   logic [TW-1:0] lk_tag = '0;
   logic          lk_hit;
   logic [63:0]   lk_data;

   always #2.5 clk = ~clk;

   pte_cache_inval u0 (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .fill_valid(fill_valid),
      .fill_tag(fill_tag), .fill_data(fill_data), .fill_ready(fill_ready),
      .lk_tag(lk_tag), .lk_hit(lk_hit), .lk_data(lk_data)
   );

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   typedef struct {
      int          kind;   // 0 lookup, 1 register read, 2 fill_ready
      string       req;
      logic [TW-1:0] tag;
      bit          hit;
      logic [63:0] exp;
   } item_t;

   item_t sb[$];

   function automatic logic [63:0] mkcmd(input int unsigned cnt, input logic [TW-1:0] t, input bit b);
      logic [10:0] c;
      c = cnt[10:0];
      return {c, 11'd0, t, 2'd0, b};
   endfunction

   function automatic logic [63:0] dv(input logic [TW-1:0] t, input int s);
      return {t[31:0] ^ 32'(s), ~t[31:0]};
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic exp_lk(input string req, input logic [TW-1:0] t, input bit h, input logic [63:0] d);
      item_t it;
      it.kind = 0; it.req = req; it.tag = t; it.hit = h; it.exp = h ? d : 64'd0;
      sb.push_back(it);
   endtask

   task automatic exp_rd(input string req, input logic [63:0] d);
      item_t it;
      it.kind = 1; it.req = req; it.tag = '0; it.hit = 1'b0; it.exp = d;
      sb.push_back(it);
   endtask

   task automatic exp_rdy(input string req, input bit r);
      item_t it;
      it.kind = 2; it.req = req; it.tag = '0; it.hit = r; it.exp = {63'd0, r};
      sb.push_back(it);
   endtask

   task automatic settle();
      wait (sb.size() == 0);
   endtask

   // monitor: pops expectations and compares 1 ns after each falling edge
   initial begin
      item_t it;
      logic [63:0] act;
      forever begin
         @(negedge clk);
         #1;
         while (sb.size() > 0) begin
            it = sb[0];
            case (it.kind)
               0: begin
                  lk_tag = it.tag;
                  #0.1;
                  act = lk_hit ? lk_data : 64'd0;
                  chk((lk_hit == it.hit) && (act == it.exp), it.req, act, it.exp);
               end
               1: chk(reg_rdata == it.exp, it.req, reg_rdata, it.exp);
               default: chk(fill_ready == it.hit, it.req, {63'd0, fill_ready}, it.exp);
            endcase
            void'(sb.pop_front());
         end
      end
   end

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         report();
         $finish;
      end
   end

   task automatic fill(input logic [TW-1:0] t, input logic [63:0] d);
      @(negedge clk);
      fill_valid = 1'b1; fill_tag = t; fill_data = d;
      @(negedge clk);
      fill_valid = 1'b0;
   endtask

   // returns on the falling edge right after the write edge
   task automatic issue(input logic [63:0] w, input logic [11:0] a);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a; reg_wdata = w;
      @(negedge clk);
      reg_we = 1'b0; reg_addr = OFF;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
   endtask

   initial begin
      logic [63:0] c1, c2, w;
      logic [TW-1:0] top;
      top = {TW{1'b1}};

      do_reset();
      exp_rd("R1 command reads zero", 64'd0);
      exp_rdy("R1 fill_ready high", 1'b1);
      exp_lk("R1 empty cache misses", TW'(32'h100), 1'b0, 64'd0);
      settle();

      // R12 lookup, R8 overwrite
      fill(TW'(32'h100), dv(TW'(32'h100), 1));
      exp_lk("R12 lookup returns data", TW'(32'h100), 1'b1, dv(TW'(32'h100), 1));
      settle();
      fill(TW'(32'h100), dv(TW'(32'h100), 2));
      exp_lk("R8 same tag overwrites data", TW'(32'h100), 1'b1, dv(TW'(32'h100), 2));
      settle();

      // R2, R3, R4: range 0x100..0x102
      fill(TW'(32'hFF),  dv(TW'(32'hFF), 1));
      fill(TW'(32'h102), dv(TW'(32'h102), 1));
      fill(TW'(32'h103), dv(TW'(32'h103), 1));
      c1 = mkcmd(3, TW'(32'h100), 1'b1);
      issue(c1, OFF);
      exp_rd("R2 readback with busy set", c1);
      exp_rdy("R7 fill_ready low in sweep", 1'b0);
      settle();
      @(negedge clk);
      exp_rd("R3 busy still set second cycle", c1);
      settle();
      @(negedge clk);
      exp_rd("R3 busy cleared, fields kept", c1 & ~64'd1);
      exp_lk("R4 below range kept", TW'(32'hFF), 1'b1, dv(TW'(32'hFF), 1));
      exp_lk("R4 range start dropped", TW'(32'h100), 1'b0, 64'd0);
      exp_lk("R4 range last dropped", TW'(32'h102), 1'b0, 64'd0);
      exp_lk("R4 range end kept", TW'(32'h103), 1'b1, dv(TW'(32'h103), 1));
      settle();

      // R6: write during busy ignored
      c1 = mkcmd(1, TW'(32'h200), 1'b1);
      c2 = mkcmd(1, TW'(32'h103), 1'b1);
      issue(c1, OFF);
      reg_we = 1'b1; reg_wdata = c2;
      exp_rd("R6 first command still shown", c1);
      settle();
      @(negedge clk);
      reg_we = 1'b0;
      exp_rd("R6 write in busy ignored", c1);
      settle();
      @(negedge clk);
      exp_rd("R6 original fields after sweep", c1 & ~64'd1);
      exp_lk("R6 ignored range not swept", TW'(32'h103), 1'b1, dv(TW'(32'h103), 1));
      settle();

      // R7: fill held off during sweep over its own tag
      c1 = mkcmd(4, TW'(32'h300), 1'b1);
      issue(c1, OFF);
      fill_valid = 1'b1; fill_tag = TW'(32'h300); fill_data = dv(TW'(32'h300), 7);
      exp_rdy("R7 fill_ready low first cycle", 1'b0);
      exp_lk("R7 fill not taken early", TW'(32'h300), 1'b0, 64'd0);
      settle();
      @(negedge clk);
      exp_rdy("R7 fill_ready low second cycle", 1'b0);
      exp_lk("R7 fill still pending", TW'(32'h300), 1'b0, 64'd0);
      settle();
      @(negedge clk);
      exp_rdy("R7 fill_ready back high", 1'b1);
      settle();
      @(negedge clk);
      fill_valid = 1'b0;
      exp_lk("R7 stalled fill lands after sweep", TW'(32'h300), 1'b1, dv(TW'(32'h300), 7));
      settle();

      // R5: count zero covers 2048 entries
      fill(TW'(32'h1000), dv(TW'(32'h1000), 1));
      fill(TW'(32'h17FF), dv(TW'(32'h17FF), 1));
      fill(TW'(32'h1800), dv(TW'(32'h1800), 1));
      fill(TW'(32'h0FFF), dv(TW'(32'h0FFF), 1));
      issue(mkcmd(0, TW'(32'h1000), 1'b1), OFF);
      repeat (2) @(negedge clk);
      exp_lk("R5 zero count start dropped", TW'(32'h1000), 1'b0, 64'd0);
      exp_lk("R5 zero count entry 2047 dropped", TW'(32'h17FF), 1'b0, 64'd0);
      exp_lk("R5 zero count entry 2048 kept", TW'(32'h1800), 1'b1, dv(TW'(32'h1800), 1));
      exp_lk("R5 below start kept", TW'(32'h0FFF), 1'b1, dv(TW'(32'h0FFF), 1));
      settle();

      // R13: range past the top tag
      fill(top - TW'(1), dv(top - TW'(1), 1));
      fill(TW'(2), dv(TW'(2), 1));
      issue(mkcmd(8, top - TW'(3), 1'b1), OFF);
      repeat (2) @(negedge clk);
      exp_lk("R13 top tag dropped", top - TW'(1), 1'b0, 64'd0);
      exp_lk("R13 low tag not wrapped", TW'(2), 1'b1, dv(TW'(2), 1));
      settle();

      // R10: busy clear, no sweep
      w = mkcmd(1, TW'(32'hFF), 1'b0);
      issue(w, OFF);
      repeat (2) @(negedge clk);
      exp_rd("R10 word stored without busy", w);
      exp_rdy("R10 no sweep, ready high", 1'b1);
      exp_lk("R10 entry untouched", TW'(32'hFF), 1'b1, dv(TW'(32'hFF), 1));
      settle();

      // R11: other offset
      issue(mkcmd(1, TW'(2), 1'b1), 12'h910);
      reg_addr = 12'h910;
      exp_rd("R11 other offset reads zero", 64'd0);
      settle();
      @(negedge clk);
      reg_addr = OFF;
      exp_rd("R11 command unchanged", w);
      exp_rdy("R11 no sweep started", 1'b1);
      settle();
      @(negedge clk);
      exp_lk("R11 entry untouched", TW'(2), 1'b1, dv(TW'(2), 1));
      settle();

      // R9: replacement order
      do_reset();
      exp_rd("R1 command zero after reset", 64'd0);
      exp_lk("R1 cache empty after reset", TW'(32'hFF), 1'b0, 64'd0);
      settle();
      for (int i = 0; i < 16; i++)
         fill(TW'(32'h5000 + i), dv(TW'(32'h5000 + i), 3));
      fill(TW'(32'h6000), dv(TW'(32'h6000), 3));
      exp_lk("R9 first victim is entry 0", TW'(32'h5000), 1'b0, 64'd0);
      exp_lk("R9 entry 1 kept", TW'(32'h5001), 1'b1, dv(TW'(32'h5001), 3));
      exp_lk("R9 new tag cached", TW'(32'h6000), 1'b1, dv(TW'(32'h6000), 3));
      settle();
      fill(TW'(32'h6000), dv(TW'(32'h6000), 4));
      exp_lk("R8 refill of full cache updates in place", TW'(32'h6000), 1'b1, dv(TW'(32'h6000), 4));
      exp_lk("R8 refill evicts nothing", TW'(32'h5001), 1'b1, dv(TW'(32'h5001), 3));
      settle();
      fill(TW'(32'h6001), dv(TW'(32'h6001), 3));
      exp_lk("R9 second victim is entry 1", TW'(32'h5001), 1'b0, 64'd0);
      exp_lk("R9 entry 2 kept", TW'(32'h5002), 1'b1, dv(TW'(32'h5002), 3));
      exp_lk("R9 second new tag cached", TW'(32'h6001), 1'b1, dv(TW'(32'h6001), 3));
      settle();

      @(negedge clk);
      finished = 1'b1;
      report();
      $finish;
   end

endmodule